// File: doc/BRIEF.md
# Packed Vector Leading-Zero Counter

This unit counts, for every lane of a packed vector, how many zero bits come before the first one, looking from the lane's most significant bit downwards. The lane width is picked per operation from a 2-bit size code: 8, 16 or 32 bits. A quad flag chooses how much of the vector is processed. When it is clear, one 64-bit register is processed. When it is set, 128 bits are processed as two adjacent 64-bit registers. Each lane's count is written back into a result lane of the same width, with zeros above the count. Signed and unsigned lanes are handled alike.

The counting is done by one shared tree for each 64-bit half. It counts every byte first, then merges pairs of byte counts into 16-bit counts and pairs of those into 32-bit counts. The size code only chooses which level is packed into the result. The unit also decodes the operation fields it receives and flags encodings that are not legal. The result and flags are registered once, so every operation finishes after one clock, whatever its data.

Top module: `simd_lzc`

## Requirements
- R1: With size code 2'b00, each half is split into 8 byte lanes. Result lane i (bits 8i+7..8i) holds the number of zeros above the highest set bit of operand lane i.
- R2: With size code 2'b01, each half is split into 4 lanes of 16 bits, counted in the same way. Result lane j occupies bits 16j+15..16j.
- R3: With size code 2'b10, each half is split into 2 lanes of 32 bits, counted in the same way. Result lane k occupies bits 32k+31..32k.
- R4: A lane that is all zeros returns its own width (8, 16 or 32). Every count is zero-extended to fill its lane.
- R5: Size code 2'b11 is illegal. out_undef is raised and out_result is all zeros.
- R6: With in_quad=1, a 1 in bit 0 of in_dst_reg or of in_src_reg makes the operation illegal. out_undef is raised and out_result is zero. With in_quad=0, the register numbers have no effect on the result.
- R7: With in_quad=0, only operand bits 63..0 are processed and result bits 127..64 are zero, whatever the upper operand bits hold.
- R8: With in_quad=1, bits 127..64 are counted as a second half, with the same lane layout as bits 63..0.
- R9: out_valid is high in exactly the cycle after a cycle with in_valid high, whatever the data. out_undef can only be high in that same cycle.
- R10: While rst_n is low, out_valid, out_undef and out_result are all zero.
- R11: out_result keeps its last value in any cycle that follows a cycle with in_valid low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation strobe |
| in_size | input | 2 | Lane width code: 00=8, 01=16, 10=32, 11=illegal |
| in_quad | input | 1 | 0: one 64-bit register, 1: two adjacent registers |
| in_dst_reg | input | 5 | Destination register number (extension bit above a 4-bit field) |
| in_src_reg | input | 5 | Source register number (extension bit above a 4-bit field) |
| in_operand | input | 128 | Packed source vector |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_undef | output | 1 | Illegal-encoding flag, qualified by out_valid |
| out_result | output | 128 | Packed per-lane counts |

## Verification
Every result, the undefined flag and the valid strobe are due on the first rising edge after the cycle in which in_valid is high. The bench drives each operation on a falling edge and removes the strobe on the next falling edge. On that same falling edge it compares all three outputs with values its own reference loop computed. One cycle later it checks that the strobe has dropped and that the result register has held its value. This timing is the same for all-zero, all-one, single-bit and random operands, so the checks also confirm that latency does not depend on the data.

// File: rtl/simd_lzc_pkg.sv
package simd_lzc_pkg;

   // Lane width selector as carried in the operation fields
   typedef enum logic [1:0] {
      LZ_B8  = 2'b00,
      LZ_B16 = 2'b01,
      LZ_B32 = 2'b10,
      LZ_BAD = 2'b11
   } lz_size_e;

   // Width of a count for a lane of w bits (must reach w itself)
   function automatic int unsigned cnt_width(input int unsigned w);
      return $clog2(w) + 1;
   endfunction

endpackage

// File: rtl/simd_lzc_seg.sv
// Leading-zero count of one base segment; all-zero yields W
module simd_lzc_seg #(
   parameter int unsigned W  = 8,
   localparam int unsigned CW = $clog2(W) + 1
) (
   input  logic [W-1:0]  seg_data,
   output logic [CW-1:0] seg_cnt
);

   initial begin
      if (W < 2 || (W & (W - 1)) != 0)
         $error("simd_lzc_seg: W must be a power of two >= 2");
   end

   always_comb begin
      seg_cnt = CW'(W);
      for (int i = 0; i < W; i++) begin
         if (seg_data[i]) seg_cnt = CW'(W - 1 - i);
      end
   end

endmodule

// File: rtl/simd_lzc_merge.sv
// Joins the counts of two adjacent lanes of IN_W bits into one lane of 2*IN_W
module simd_lzc_merge #(
   parameter int unsigned IN_W = 8,
   localparam int unsigned CWI = $clog2(IN_W) + 1,
   localparam int unsigned CWO = $clog2(2 * IN_W) + 1
) (
   input  logic [CWI-1:0] cnt_hi,
   input  logic [CWI-1:0] cnt_lo,
   output logic [CWO-1:0] cnt_out
);

   logic hi_empty;

   initial begin
      if (IN_W < 2 || (IN_W & (IN_W - 1)) != 0)
         $error("simd_lzc_merge: IN_W must be a power of two >= 2");
   end

   assign hi_empty = (cnt_hi == CWI'(IN_W));
   assign cnt_out  = hi_empty ? (CWO'(IN_W) + CWO'(cnt_lo)) : CWO'(cnt_hi);

endmodule

// File: rtl/simd_lzc_decode.sv
// Legality check of the operation fields
module simd_lzc_decode
   import simd_lzc_pkg::*;
#(
   parameter int unsigned REG_W = 5
) (
   input  lz_size_e         dec_size,
   input  logic             dec_quad,
   input  logic [REG_W-1:0] dec_dst,
   input  logic [REG_W-1:0] dec_src,
   output logic             dec_illegal
);

   logic bad_size;
   logic bad_pair;
   logic unused_reg_hi;

   initial begin
      if (REG_W < 2) $error("simd_lzc_decode: REG_W must be >= 2");
   end

   // A register pair must start on an even register number
   assign bad_size      = (dec_size == LZ_BAD);
   assign bad_pair      = dec_quad & (dec_dst[0] | dec_src[0]);
   assign dec_illegal   = bad_size | bad_pair;
   assign unused_reg_hi = ^{dec_dst[REG_W-1:1], dec_src[REG_W-1:1]};

endmodule

// File: rtl/simd_lzc_half.sv
// Shared count tree for one register-sized half of the vector
module simd_lzc_half
   import simd_lzc_pkg::*;
#(
   parameter int unsigned HALF_W = 64,
   parameter int unsigned SEG_W  = 8,
   localparam int unsigned W16    = 2 * SEG_W,
   localparam int unsigned W32    = 4 * SEG_W,
   localparam int unsigned N8     = HALF_W / SEG_W,
   localparam int unsigned N16    = N8 / 2,
   localparam int unsigned N32    = N8 / 4,
   localparam int unsigned CW8    = $clog2(SEG_W) + 1,
   localparam int unsigned CW16   = $clog2(W16) + 1,
   localparam int unsigned CW32   = $clog2(W32) + 1
) (
   input  logic [HALF_W-1:0] half_data,
   input  lz_size_e          half_size,
   output logic [HALF_W-1:0] half_cnt
);

   logic [CW8-1:0]  c8  [N8];
   logic [CW16-1:0] c16 [N16];
   logic [CW32-1:0] c32 [N32];

   initial begin
      if (HALF_W % W32 != 0)
         $error("simd_lzc_half: HALF_W must be a multiple of 4*SEG_W");
      if (SEG_W != 8)
         $error("simd_lzc_half: size codes assume 8-bit base segments");
   end

   // Level 0: byte counts
   for (genvar i = 0; i < N8; i++) begin : g_seg
      simd_lzc_seg #(.W(SEG_W)) u_seg (
         .seg_data (half_data[i*SEG_W +: SEG_W]),
         .seg_cnt  (c8[i])
      );
   end

   // Level 1: 16-bit lanes from byte pairs
   for (genvar j = 0; j < N16; j++) begin : g_m16
      simd_lzc_merge #(.IN_W(SEG_W)) u_m16 (
         .cnt_hi  (c8[2*j+1]),
         .cnt_lo  (c8[2*j]),
         .cnt_out (c16[j])
      );
   end

   // Level 2: 32-bit lanes from 16-bit pairs
   for (genvar k = 0; k < N32; k++) begin : g_m32
      simd_lzc_merge #(.IN_W(W16)) u_m32 (
         .cnt_hi  (c16[2*k+1]),
         .cnt_lo  (c16[2*k]),
         .cnt_out (c32[k])
      );
   end

   // Size code picks which tree level fills the lanes
   always_comb begin
      half_cnt = '0;
      unique case (half_size)
         LZ_B8: begin
            for (int i = 0; i < N8; i++)
               half_cnt[i*SEG_W +: SEG_W] = SEG_W'(c8[i]);
         end
         LZ_B16: begin
            for (int j = 0; j < N16; j++)
               half_cnt[j*W16 +: W16] = W16'(c16[j]);
         end
         LZ_B32: begin
            for (int k = 0; k < N32; k++)
               half_cnt[k*W32 +: W32] = W32'(c32[k]);
         end
         default: half_cnt = '0;
      endcase
   end

endmodule

// File: rtl/simd_lzc.sv
// Packed vector leading-zero counter, one register stage
module simd_lzc
   import simd_lzc_pkg::*;
#(
   parameter int unsigned HALF_W = 64,
   parameter int unsigned SEG_W  = 8,
   parameter int unsigned REG_W  = 5,
   localparam int unsigned VEC_W  = 2 * HALF_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [1:0]       in_size,
   input  logic             in_quad,
   input  logic [REG_W-1:0] in_dst_reg,
   input  logic [REG_W-1:0] in_src_reg,
   input  logic [VEC_W-1:0] in_operand,
   output logic             out_valid,
   output logic             out_undef,
   output logic [VEC_W-1:0] out_result
);

   lz_size_e         size_e;
   logic             illegal;
   logic [VEC_W-1:0] counts;
   logic [VEC_W-1:0] counts_gated;
   logic             valid_q;
   logic             undef_q;
   logic [VEC_W-1:0] result_q;

   assign size_e = lz_size_e'(in_size);

   simd_lzc_decode #(.REG_W(REG_W)) u_dec (
      .dec_size    (size_e),
      .dec_quad    (in_quad),
      .dec_dst     (in_dst_reg),
      .dec_src     (in_src_reg),
      .dec_illegal (illegal)
   );

   for (genvar h = 0; h < 2; h++) begin : g_half
      simd_lzc_half #(.HALF_W(HALF_W), .SEG_W(SEG_W)) u_half (
         .half_data (in_operand[h*HALF_W +: HALF_W]),
         .half_size (size_e),
         .half_cnt  (counts[h*HALF_W +: HALF_W])
      );
   end

   // Upper half only contributes for two-register operations
   assign counts_gated = {counts[VEC_W-1:HALF_W] & {HALF_W{in_quad}},
                          counts[HALF_W-1:0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q  <= 1'b0;
         undef_q  <= 1'b0;
         result_q <= '0;
      end else begin
         valid_q <= in_valid;
         undef_q <= in_valid & illegal;
         if (in_valid) result_q <= illegal ? '0 : counts_gated;
      end
   end

   assign out_valid  = valid_q;
   assign out_undef  = undef_q;
   assign out_result = result_q;

endmodule

// File: rtl/simd_lzc_checker.sv
module simd_lzc_checker #(
   parameter int unsigned HALF_W = 64,
   parameter int unsigned SEG_W  = 8,
   parameter int unsigned REG_W  = 5,
   localparam int unsigned VEC_W  = 2 * HALF_W
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic [1:0]       in_size,
   input logic             in_quad,
   input logic [REG_W-1:0] in_dst_reg,
   input logic [REG_W-1:0] in_src_reg,
   input logic [VEC_W-1:0] in_operand,
   input logic             out_valid,
   input logic             out_undef,
   input logic [VEC_W-1:0] out_result
);

   logic odd_reg;
   logic legal_in;
   logic unused_chk;

   assign odd_reg    = in_dst_reg[0] | in_src_reg[0];
   assign legal_in   = (in_size != 2'b11) && !(in_quad && odd_reg);
   assign unused_chk = ^{in_dst_reg, in_src_reg};

   AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);                                       // R9
   AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);                                     // R9
   AST_UNDEF_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
      out_undef |-> out_valid);                                      // R9
   AST_BAD_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_size == 2'b11) |=> (out_undef && out_result == '0)); // R5
   AST_BAD_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_quad && odd_reg) |=> (out_undef && out_result == '0)); // R6
   AST_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_quad) |=> (out_result[VEC_W-1:HALF_W] == '0)); // R7
   AST_EMPTY_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && legal_in && in_size == 2'b00 && in_operand[SEG_W-1:0] == '0)
      |=> (out_result[SEG_W-1:0] == SEG_W'(SEG_W)));                // R4
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_result));                            // R11
   AST_RESET_QUIET: assert property (@(posedge clk)
      !rst_n |-> (!out_valid && !out_undef && out_result == '0));     // R10

endmodule

bind simd_lzc simd_lzc_checker #(
   .HALF_W (HALF_W),
   .SEG_W  (SEG_W),
   .REG_W  (REG_W)
) u_chk (.*);

// File: tb/simd_lzc_bench.sv
`timescale 1ns/1ps
module simd_lzc_bench;

   logic         clk;
   logic         rst_n;
   logic         in_valid;
   logic [1:0]   in_size;
   logic         in_quad;
   logic [4:0]   in_dst_reg;
   logic [4:0]   in_src_reg;
   logic [127:0] in_operand;
   logic         out_valid;
   logic         out_undef;
   logic [127:0] out_result;

   int checks   = 0;
   int failures = 0;
   bit done     = 0;

   simd_lzc u_simd_lzc (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .in_size    (in_size),
      .in_quad    (in_quad),
      .in_dst_reg (in_dst_reg),
      .in_src_reg (in_src_reg),
      .in_operand (in_operand),
      .out_valid  (out_valid),
      .out_undef  (out_undef),
      .out_result (out_result)
   );

   initial clk = 1'b0;
   always #4 clk = ~clk;

   // Reference: walk each lane from its top bit
   function automatic logic [127:0] ref_counts(input logic [127:0] op,
                                               input logic [1:0] sz,
                                               input logic q);
      logic [127:0] res = '0;
      int w     = 8 << sz;
      int lanes = (q ? 128 : 64) / w;
      for (int l = 0; l < lanes; l++) begin
         int  cnt   = 0;
         bit  found = 0;
         for (int b = w - 1; b >= 0; b--) begin
            if (!found) begin
               if (op[l*w + b]) found = 1;
               else cnt++;
            end
         end
         res = res | (128'(cnt) << (l * w));
      end
      return res;
   endfunction

   task automatic check(input bit ok, input string req,
                        input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic run_op(input logic [1:0] sz, input logic q,
                         input logic [4:0] d, input logic [4:0] s,
                         input logic [127:0] op, input string req);
      logic         exp_undef;
      logic [127:0] exp_res;
      exp_undef = (sz == 2'b11) || (q && (d[0] || s[0]));
      exp_res   = exp_undef ? '0 : ref_counts(op, sz, q);
      @(negedge clk);
      check(out_valid == 1'b0, "R9 idle before", 128'(out_valid), 128'(0));
      in_size = sz; in_quad = q; in_dst_reg = d; in_src_reg = s;
      in_operand = op; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check(out_valid == 1'b1, "R9 valid after one cycle", 128'(out_valid), 128'(1));
      check(out_undef == exp_undef, "R5/R6 undef flag", 128'(out_undef), 128'(exp_undef));
      check(out_result == exp_res, req, out_result, exp_res);
      @(negedge clk);
      check(out_valid == 1'b0 && out_undef == 1'b0, "R9 strobe drops",
            128'({out_valid, out_undef}), 128'(0));
      check(out_result == exp_res, "R11 result held", out_result, exp_res);
   endtask

   function automatic logic [127:0] rand_op();
      logic [127:0] v;
      for (int i = 0; i < 4; i++) begin
         logic [31:0] w = $urandom;
         int sh = $urandom_range(0, 32);
         v[i*32 +: 32] = (sh == 32) ? 32'd0 : (w >> sh);
      end
      return v;
   endfunction

   initial begin
      #(8 * 150000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      rst_n = 1'b0; in_valid = 1'b0; in_size = '0; in_quad = 1'b0;
      in_dst_reg = '0; in_src_reg = '0; in_operand = '0;
      repeat (3) @(negedge clk);
      check(out_valid == 0 && out_undef == 0 && out_result == '0, "R10 reset state",
            out_result, '0);
      rst_n = 1'b1;

      // All-zero lanes return the width (R4)
      run_op(2'b00, 1'b1, 5'd2, 5'd4, '0, "R4 R1 empty bytes");
      run_op(2'b01, 1'b1, 5'd2, 5'd4, '0, "R4 R2 empty halfwords");
      run_op(2'b10, 1'b1, 5'd2, 5'd4, '0, "R4 R3 empty words");
      // All-ones give zero counts
      run_op(2'b00, 1'b1, 5'd0, 5'd0, '1, "R1 all ones");
      run_op(2'b10, 1'b1, 5'd0, 5'd0, '1, "R3 all ones");
      // Only the lowest bit of each lane set
      run_op(2'b00, 1'b1, 5'd6, 5'd8, {16{8'h01}}, "R1 lsb only");
      run_op(2'b01, 1'b1, 5'd6, 5'd8, {8{16'h0001}}, "R2 lsb only");
      run_op(2'b10, 1'b1, 5'd6, 5'd8, {4{32'h0000_0001}}, "R3 lsb only");
      // Lane boundary: bit just below a lane top, next lane empty
      run_op(2'b01, 1'b1, 5'd0, 5'd2, {8{16'h0080}}, "R2 byte carry");
      run_op(2'b10, 1'b1, 5'd0, 5'd2, {4{32'h0000_8000}}, "R3 halfword carry");
      // Illegal size code (R5)
      run_op(2'b11, 1'b0, 5'd0, 5'd0, '1, "R5 illegal size result");
      // Odd register numbers with quad (R6) and without
      run_op(2'b00, 1'b1, 5'd3, 5'd4, '1, "R6 odd destination");
      run_op(2'b01, 1'b1, 5'd4, 5'd17, '1, "R6 odd source");
      run_op(2'b01, 1'b0, 5'd3, 5'd17, {64'hFFFF, 64'h0001_0100_0000_8000},
             "R6 R7 odd regs legal single");
      // Upper operand ignored for single register (R7), used for pair (R8)
      run_op(2'b10, 1'b0, 5'd0, 5'd0, {64'h1234_0000_0000_0001, 64'h0000_0010_8000_0000},
             "R7 upper ignored");
      run_op(2'b10, 1'b1, 5'd0, 5'd0, {64'h1234_0000_0000_0001, 64'h0000_0010_8000_0000},
             "R8 both halves");

      for (int n = 0; n < 400; n++) begin
         logic [1:0] sz = 2'($urandom_range(0, 3));
         logic       q  = 1'($urandom);
         logic [4:0] d  = 5'($urandom);
         logic [4:0] s  = 5'($urandom);
         if ($urandom_range(0, 3) != 0) begin
            d[0] = 1'b0; s[0] = 1'b0;
         end
         if (sz == 2'b11 && $urandom_range(0, 3) != 0) sz = 2'b00;
         run_op(sz, q, d, s, rand_op(), "R1 R2 R3 R8 random");
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule